// File: doc/BRIEF.md
# Prescaled Raster Interrupt Timer

This block raises a level interrupt toward the CPU after a programmable number of time units. A unit is either one CPU cycle or one approximate display line. The line is formed by a prescaler that starts from 341 and loses 3 for each enabled CPU cycle. When the prescaler drops to zero or below, it gains 341 back and clocks the main counter. The main counter is an 8-bit up-counter. Each time it wraps past its maximum value, it reloads from a software latch and asserts the interrupt.

The CPU programs the block through a write port. Only writes whose top address nibble equals the register group are accepted. Within the group, the register is chosen by OR-ing address bits [1:0] with address bits [3:2], so either address-bit pair can reach any register. The latch is written in two 4-bit halves. A control write sets the enable, the cycle-mode bit and the enable-after-acknowledge bit. An acknowledge write copies the enable-after-acknowledge bit into the enable and drops the interrupt. Time only advances on cycles where the CPU clock enable is high.

Top module: `irq_cycle_timer`

## Requirements
- R1: Synchronous reset clears the latch, control bits, counter, prescaler and interrupt. After reset the interrupt is low. If counting is then enabled without a reload (control 0x05 followed by an acknowledge), the interrupt asserts after exactly 256 enabled CPU cycles.
- R2: A write is accepted only when wr_addr[15:12] is 0xF. Register select is wr_addr[1:0] | wr_addr[3:2]: 0 is latch low, 1 is latch high, 2 is control, 3 is acknowledge. Writes to any other group change nothing.
- R3: Select 0 writes wr_data[3:0] into latch bits [3:0]. Select 1 writes wr_data[3:0] into latch bits [7:4].
- R4: A control write stores wr_data[2:0], where bit 0 is enable-after-acknowledge, bit 1 is enable and bit 2 is cycle mode. The write always clears the interrupt. When bit 1 is set, it also loads the counter from the latch and the prescaler with 341.
- R5: An acknowledge write sets enable to the stored bit 0 and clears the interrupt. It reloads neither the counter nor the prescaler.
- R6: In cycle mode with enable set, every enabled CPU cycle clocks the counter. With latch L loaded, the interrupt asserts after 256-L such cycles.
- R7: In line mode with enable set, each enabled CPU cycle subtracts 3 from the prescaler. A result of zero or below adds 341 and clocks the counter. After a load with latch 0xFF, the interrupt asserts on the 114th enabled cycle and not on the 113th.
- R8: Clocking the counter at 0xFF reloads it from the latch and sets the interrupt. The interrupt stays high until a control or acknowledge write.
- R9: With the CPU clock enable low, or with enable clear, neither the counter nor the prescaler moves.
- R10: A cycle carrying an accepted write does not advance the counter or the prescaler, even when the CPU clock enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_ce | input | 1 | One-cycle CPU clock enable |
| wr_en | input | 1 | CPU write strobe |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| irq | output | 1 | Registered level interrupt |

## Verification
The bench builds the block with its default parameters: an 8-bit counter, a 10-bit signed prescaler, a reload of 341 and a step of 3. The reload and step are small enough that a full line-mode period of 114 CPU cycles fits in a short run, so the exact underflow edge of the prescaler can be checked directly. The 8-bit counter lets a reset-state wrap of 256 cycles be watched end to end. Mixed random writes, including aliased selects and writes to foreign groups, reach write-versus-count collisions and acknowledge re-enables without a reload.

// File: rtl/irq_timer_pkg.sv
package irq_timer_pkg;
  typedef enum logic [1:0] {
    SEL_LAT_LO = 2'd0,
    SEL_LAT_HI = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_ACK    = 2'd3
  } sel_e;

  typedef struct packed {
    logic cyc_mode;
    logic en;
    logic en_after_ack;
  } ctrl_t;
endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode #(
  parameter int AW  = 16,
  parameter int GRP = 15
) (
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  output logic          grp_hit,
  output logic          wr_lo,
  output logic          wr_hi,
  output logic          wr_ctrl,
  output logic          wr_ack
);
  import irq_timer_pkg::*;

  sel_e sel;

  always_comb begin
    grp_hit = wr_en && (wr_addr[AW-1:AW-4] == 4'(GRP));
    sel     = sel_e'(wr_addr[1:0] | wr_addr[3:2]);
    wr_lo   = grp_hit && (sel == SEL_LAT_LO);
    wr_hi   = grp_hit && (sel == SEL_LAT_HI);
    wr_ctrl = grp_hit && (sel == SEL_CTRL);
    wr_ack  = grp_hit && (sel == SEL_ACK);
  end
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs #(
  parameter int DW    = 8,
  parameter int CNT_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_lo,
  input  logic                  wr_hi,
  input  logic                  wr_ctrl,
  input  logic                  wr_ack,
  input  logic [DW-1:0]         wr_data,
  output logic [CNT_W-1:0]      latch_q,
  output irq_timer_pkg::ctrl_t  ctrl_q
);
  import irq_timer_pkg::*;

  localparam int NIB = CNT_W / 2;

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
      ctrl_q  <= '0;
    end else begin
      if (wr_lo) latch_q[NIB-1:0]     <= wr_data[NIB-1:0];
      if (wr_hi) latch_q[CNT_W-1:NIB] <= wr_data[NIB-1:0];
      if (wr_ctrl) ctrl_q <= ctrl_t'(wr_data[2:0]);
      else if (wr_ack) ctrl_q.en <= ctrl_q.en_after_ack;
    end
  end
endmodule

// File: rtl/irq_prescaler.sv
module irq_prescaler #(
  parameter int PRE_W  = 10,
  parameter int RELOAD = 341,
  parameter int STEP   = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cpu_ce,
  input  logic                    en,
  input  logic                    cyc_mode,
  input  logic                    hold,
  input  logic                    reload,
  output logic                    tick,
  output logic signed [PRE_W-1:0] pre_q
);
  localparam logic signed [PRE_W-1:0] RELOAD_V = PRE_W'(RELOAD);
  localparam logic signed [PRE_W-1:0] STEP_V   = PRE_W'(STEP);

  logic signed [PRE_W-1:0] pre_dec;
  logic                    under;
  logic                    run;

  always_comb begin
    pre_dec = pre_q - STEP_V;
    under   = (pre_dec <= 0);
    run     = cpu_ce && en && !hold;
    tick    = run && (cyc_mode || under);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
    end else if (reload) begin
      pre_q <= RELOAD_V;
    end else if (run && !cyc_mode) begin
      pre_q <= under ? (pre_dec + RELOAD_V) : pre_dec;
    end
  end
endmodule

// File: rtl/irq_up_counter.sv
module irq_up_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic             clr,
  input  logic [CNT_W-1:0] latch,
  output logic [CNT_W-1:0] cnt_q,
  output logic             irq_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic wrap;

  assign wrap = tick && (cnt_q == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load || wrap) begin
      cnt_q <= latch;
    end else if (tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       irq_q <= 1'b0;
    else if (clr)  irq_q <= 1'b0;
    else if (wrap) irq_q <= 1'b1;
  end
endmodule

// File: rtl/irq_cycle_timer.sv
module irq_cycle_timer #(
  parameter int AW     = 16,
  parameter int DW     = 8,
  parameter int GRP    = 15,
  parameter int CNT_W  = 8,
  parameter int PRE_W  = 10,
  parameter int RELOAD = 341,
  parameter int STEP   = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_ce,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          irq
);
  import irq_timer_pkg::*;

  logic                    grp_hit, wr_lo, wr_hi, wr_ctrl, wr_ack;
  logic [CNT_W-1:0]        latch_q;
  ctrl_t                   ctrl_q;
  logic                    tick;
  logic                    do_load;
  logic signed [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0]        cnt_q;
  logic                    irq_q;

  assign do_load = wr_ctrl && wr_data[1];

  irq_reg_decode #(.AW(AW), .GRP(GRP)) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .grp_hit(grp_hit),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_ctrl(wr_ctrl), .wr_ack(wr_ack)
  );

  irq_ctrl_regs #(.DW(DW), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .wr_ctrl(wr_ctrl), .wr_ack(wr_ack), .wr_data(wr_data),
    .latch_q(latch_q), .ctrl_q(ctrl_q)
  );

  irq_prescaler #(.PRE_W(PRE_W), .RELOAD(RELOAD), .STEP(STEP)) u_pre (
    .clk(clk), .rst(rst), .cpu_ce(cpu_ce), .en(ctrl_q.en),
    .cyc_mode(ctrl_q.cyc_mode), .hold(grp_hit), .reload(do_load),
    .tick(tick), .pre_q(pre_q)
  );

  irq_up_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .load(do_load),
    .clr(wr_ctrl || wr_ack), .latch(latch_q),
    .cnt_q(cnt_q), .irq_q(irq_q)
  );

  assign irq = irq_q;
endmodule

// File: rtl/irq_timer_chk.sv
module irq_timer_chk #(
  parameter int AW     = 16,
  parameter int DW     = 8,
  parameter int GRP    = 15,
  parameter int CNT_W  = 8,
  parameter int PRE_W  = 10,
  parameter int RELOAD = 341
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    cpu_ce,
  input logic                    wr_en,
  input logic [AW-1:0]           wr_addr,
  input logic [DW-1:0]           wr_data,
  input logic                    irq,
  input logic [CNT_W-1:0]        cnt_q,
  input logic [CNT_W-1:0]        latch_q,
  input logic signed [PRE_W-1:0] pre_q
);
  logic       hit;
  logic [1:0] sel;

  assign hit = wr_en && (wr_addr[AW-1:AW-4] == 4'(GRP));
  assign sel = wr_addr[1:0] | wr_addr[3:2];

  // R4
  ctrl_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (hit && sel == 2'd2) |=> !irq);

  // R4
  ctrl_load_chk: assert property (@(posedge clk) disable iff (rst)
    (hit && sel == 2'd2 && wr_data[1]) |=> (cnt_q == $past(latch_q)));

  // R5
  ack_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (hit && sel == 2'd3) |=> !irq);

  // R8
  irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> ($past(cnt_q) == {CNT_W{1'b1}}));

  // R9
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!cpu_ce && !wr_en) |=> ($stable(cnt_q) && $stable(irq) && $stable(pre_q)));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (hit && sel != 2'd2) |=> ($stable(cnt_q) && $stable(pre_q)));

  // R7
  pre_range_chk: assert property (@(posedge clk) disable iff (rst)
    (pre_q >= 0) && (pre_q <= PRE_W'(RELOAD)));
endmodule

bind irq_cycle_timer irq_timer_chk #(
  .AW(AW), .DW(DW), .GRP(GRP), .CNT_W(CNT_W), .PRE_W(PRE_W), .RELOAD(RELOAD)
) i_chk (
  .clk(clk), .rst(rst), .cpu_ce(cpu_ce), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .irq(irq), .cnt_q(cnt_q), .latch_q(latch_q), .pre_q(pre_q)
);

// File: tb/test_irq_cycle_timer.sv
module test_irq_cycle_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_ce = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;

  logic [7:0] m_lat, m_cnt;
  logic [2:0] m_ctrl;
  int         m_pre;
  logic       m_irq;

  always #10 clk = ~clk;

  irq_cycle_timer i_irq_cycle_timer (
    .clk(clk), .rst(rst), .cpu_ce(cpu_ce), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .irq(irq)
  );

  task automatic model_reset();
    m_lat = '0; m_cnt = '0; m_ctrl = '0; m_pre = 0; m_irq = 1'b0;
  endtask

  task automatic model_step(input logic we, input logic [15:0] a,
                            input logic [7:0] d, input logic ce);
    logic       hit, t;
    logic [1:0] s;
    hit = we && (a[15:12] == 4'hF);
    s   = a[1:0] | a[3:2];
    t   = 1'b0;
    if (hit) begin
      case (s)
        2'd0: m_lat[3:0] = d[3:0];
        2'd1: m_lat[7:4] = d[3:0];
        2'd2: begin
          m_ctrl = d[2:0]; m_irq = 1'b0;
          if (d[1]) begin m_cnt = m_lat; m_pre = 341; end
        end
        default: begin m_ctrl[1] = m_ctrl[0]; m_irq = 1'b0; end
      endcase
    end else if (ce && m_ctrl[1]) begin
      if (m_ctrl[2]) t = 1'b1;
      else begin
        m_pre = m_pre - 3;
        if (m_pre <= 0) begin m_pre = m_pre + 341; t = 1'b1; end
      end
      if (t) begin
        if (m_cnt == 8'hFF) begin m_cnt = m_lat; m_irq = 1'b1; end
        else m_cnt = m_cnt + 8'd1;
      end
    end
  endtask

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s irq actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // Starts and ends at a negedge; compares irq to the bench model.
  task automatic cyc(input logic we, input logic [15:0] a, input logic [7:0] d,
                     input logic ce, input string tag);
    wr_en = we; wr_addr = a; wr_data = d; cpu_ce = ce;
    @(posedge clk);
    @(negedge clk);
    model_step(we, a, d, ce);
    check(tag, irq, m_irq);
  endtask

  task automatic idle_ce(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 16'h0000, 8'h00, 1'b1, tag);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    model_reset();
    @(negedge clk);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset", irq, 1'b0);

    // R1: counter reset to 0, enable via ack without reload -> 256 cycles
    cyc(1'b1, 16'hF002, 8'h05, 1'b0, "R1");
    cyc(1'b1, 16'hF003, 8'h00, 1'b0, "R1");
    idle_ce(255, "R1");
    check("R1 before wrap", irq, 1'b0);
    idle_ce(1, "R1");
    check("R1 wrap", irq, 1'b1);

    // R3 R2: latch 0xFD through aliased selects, control via F008
    cyc(1'b1, 16'hF000, 8'hAD, 1'b1, "R3");
    cyc(1'b1, 16'hF004, 8'h7F, 1'b1, "R2");
    cyc(1'b1, 16'hF008, 8'h06, 1'b1, "R4");
    check("R4 clear", irq, 1'b0);
    idle_ce(2, "R6");
    check("R6 before", irq, 1'b0);
    idle_ce(1, "R6");
    check("R6 after 3", irq, 1'b1);
    // R2: foreign group control write ignored
    cyc(1'b1, 16'hE002, 8'h06, 1'b1, "R2");
    check("R2 foreign", irq, 1'b1);
    // R8: held
    idle_ce(5, "R8");
    check("R8 held", irq, 1'b1);
    // R5: ack via F00C with bit0 clear -> disabled
    cyc(1'b1, 16'hF00C, 8'h00, 1'b1, "R5");
    check("R5 ack", irq, 1'b0);
    idle_ce(300, "R9");
    check("R9 disabled", irq, 1'b0);

    // R10: latch FE, cycle mode, write in the middle delays one cycle
    cyc(1'b1, 16'hF000, 8'h0E, 1'b0, "R3");
    cyc(1'b1, 16'hF001, 8'h0F, 1'b0, "R3");
    cyc(1'b1, 16'hF002, 8'h06, 1'b1, "R4");
    idle_ce(1, "R10");
    cyc(1'b1, 16'hF000, 8'h0E, 1'b1, "R10");
    check("R10 held", irq, 1'b0);
    idle_ce(1, "R10");
    check("R10 after", irq, 1'b1);

    // R9: ce low does nothing
    cyc(1'b1, 16'hF002, 8'h06, 1'b0, "R4");
    for (int i = 0; i < 20; i++) cyc(1'b0, 16'h0000, 8'h00, 1'b0, "R9");
    check("R9 ce low", irq, 1'b0);

    // R7: line mode with latch 0xFF
    cyc(1'b1, 16'hF000, 8'h0F, 1'b0, "R3");
    cyc(1'b1, 16'hF002, 8'h02, 1'b0, "R7");
    idle_ce(113, "R7");
    check("R7 at 113", irq, 1'b0);
    idle_ce(1, "R7");
    check("R7 at 114", irq, 1'b1);

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      logic        we;
      logic [15:0] a;
      we = ($urandom % 100) < 12;
      a  = 16'($urandom);
      if (($urandom % 8) != 0) a[15:12] = 4'hF;
      cyc(we, a, 8'($urandom), ($urandom % 4) != 0, "R6/R7 random");
    end

    // Random line-mode runs with short latches
    for (int k = 0; k < 4; k++) begin
      cyc(1'b1, 16'hF000, 8'($urandom), 1'b0, "R3");
      cyc(1'b1, 16'hF001, 8'h0F, 1'b0, "R3");
      cyc(1'b1, 16'hF002, 8'h03, 1'b0, "R7");
      for (int i = 0; i < 2500; i++)
        cyc(1'b0, 16'h0000, 8'h00, ($urandom % 3) != 0, "R7 run");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule